// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory operation at a time against a single-port synchronous memory. A request carries a base address, a signed 16-bit displacement, the source operand, the value of the accumulator register R0, a 2-bit width select and a 32-bit operation code. The unit reads the addressed location and computes the new value. It writes that value back when the operation calls for it. It then reports the values to be written into the source register or into R0. While the read, compute and write steps run, a lock output is held high. An outer arbiter uses the lock to keep every other agent away from the memory.

Requests use a valid/ready handshake. `req_ready` is high only while the unit is idle, and a request transfers on a cycle where both `req_valid` and `req_ready` are high. Holding `req_valid` with `req_ready` low is back-pressure: the request waits and no fields are sampled. The result does not use a handshake. `done` pulses for one cycle, and the register write-back enables and values are valid only in that cycle. The memory port has no stall: a read issued in one cycle returns its data on `mem_rdata` in the next cycle.

Top module: `atomic_rmw_unit`

## Requirements
- R1: `req_ready` is high exactly when the unit is idle. A request is accepted on a cycle with `req_valid && req_ready`, and `req_ready` stays low from the cycle after acceptance through the `done` cycle.
- R2: The memory address presented for both read and write equals `req_base` plus `req_offset` sign-extended to 64 bits.
- R3: Width code 2'b00 selects a 32-bit word and 2'b11 selects a 64-bit doubleword, with `mem_dword` showing which. Word operations use only bits 31:0 of memory data, source and R0. They write data whose upper 32 bits are zero, and they return zero-extended values.
- R4: Operation codes 0x00 (add), 0x40 (or), 0x50 (and) and 0xA0 (xor) write the old memory value combined with the source value, with wrap-around on add.
- R5: Setting bit 0 of the simple operation codes (0x01, 0x41, 0x51, 0xA1) makes `src_we` pulse with `src_val` equal to the pre-update memory value. Without that bit, `src_we` stays low.
- R6: Code 0xE1 (exchange) writes the source value to memory and returns the old memory value through `src_we`/`src_val`.
- R7: Code 0xF1 (compare-exchange) writes the source value only when the old memory value equals R0 over the operation width. In both cases `r0_we` pulses with `r0_val` equal to the zero-extended old value, and `src_we` stays low.
- R8: Any other operation code, or width code 2'b01 or 2'b10, produces `done` with `err` high, no memory access and no register write-back, one cycle after acceptance.
- R9: `mem_lock` is high from the read cycle through the write cycle, and `mem_en` is never high without `mem_lock`.
- R10: `done` is high for a single cycle. `src_we` and `r0_we` are high only in that cycle.
- R11: The read is issued in the cycle after acceptance. `done` follows 4 cycles after acceptance when a write occurs, and 3 cycles after acceptance when a compare-exchange fails.
- R12: After reset the unit is idle with `req_ready` high and `done`, `mem_en` and `mem_lock` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_base | input | 64 | Base address register value |
| req_offset | input | 16 | Signed address displacement |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | R0 value for compare-exchange |
| req_size | input | 2 | Width code: 00 word, 11 doubleword |
| req_imm | input | 32 | Operation code |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_dword | output | 1 | Access is 64-bit when high, 32-bit when low |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read |
| mem_lock | output | 1 | Memory lock for the whole read-modify-write |
| done | output | 1 | Operation finished (one-cycle pulse) |
| err | output | 1 | Request rejected, valid with done |
| src_we | output | 1 | Write `src_val` into the source register |
| src_val | output | 64 | Old memory value for the source register |
| r0_we | output | 1 | Write `r0_val` into R0 |
| r0_val | output | 64 | Old memory value for R0 |

## Verification
The assertions assume that `mem_rdata` carries the addressed data exactly one cycle after a read strobe. They also assume that nothing else touches memory while `mem_lock` is high, so the value that is modified is the value that was read. The bench memory model replies with a fixed one-cycle latency. For word reads it deliberately fills the upper half of `mem_rdata` with the inverse of the selected word, so that unmasked upper bits are caught. Random requests choose their effective address first and derive the base from a random signed offset, so every access lands on an aligned location inside the modelled region.

// File: rtl/atom_pkg.sv
package atom_pkg;
  typedef enum logic [2:0] {
    OP_ADD, OP_OR, OP_AND, OP_XOR, OP_XCHG, OP_CMPX
  } atom_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CALC, ST_WRITE, ST_DONE
  } atom_state_e;

  localparam logic [1:0] SZ_WORD  = 2'b00;
  localparam logic [1:0] SZ_DWORD = 2'b11;
endpackage

// File: rtl/atom_decode.sv
module atom_decode
  import atom_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [IMM_W-1:0] imm,
  input  logic [1:0]       size,
  output atom_op_e         op,
  output logic             fetch,
  output logic             dword,
  output logic             bad
);
  localparam logic [IMM_W-1:0] C_ADD = IMM_W'(8'h00);
  localparam logic [IMM_W-1:0] C_OR  = IMM_W'(8'h40);
  localparam logic [IMM_W-1:0] C_AND = IMM_W'(8'h50);
  localparam logic [IMM_W-1:0] C_XOR = IMM_W'(8'hA0);
  localparam logic [IMM_W-1:0] C_XCH = IMM_W'(8'hE1);
  localparam logic [IMM_W-1:0] C_CMP = IMM_W'(8'hF1);
  localparam logic [IMM_W-1:0] C_FET = IMM_W'(8'h01);

  logic imm_ok;

  always_comb begin
    op     = OP_ADD;
    imm_ok = 1'b1;
    case (imm)
      C_ADD, C_ADD | C_FET: op = OP_ADD;
      C_OR,  C_OR  | C_FET: op = OP_OR;
      C_AND, C_AND | C_FET: op = OP_AND;
      C_XOR, C_XOR | C_FET: op = OP_XOR;
      C_XCH:                op = OP_XCHG;
      C_CMP:                op = OP_CMPX;
      default:              imm_ok = 1'b0;
    endcase
  end

  assign fetch = imm[0];
  assign dword = (size == SZ_DWORD);
  assign bad   = !imm_ok || !((size == SZ_WORD) || (size == SZ_DWORD));
endmodule

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  atom_op_e          op,
  input  logic              dword,
  input  logic [DATA_W-1:0] mem_old,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] r0,
  output logic [DATA_W-1:0] old_val,
  output logic [DATA_W-1:0] new_val,
  output logic              cmp_ok
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] mask, o, s, r, raw;

  assign mask = dword ? {DATA_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
  assign o = mem_old & mask;
  assign s = src & mask;
  assign r = r0 & mask;
  assign cmp_ok = (o == r);

  always_comb begin
    case (op)
      OP_ADD:  raw = o + s;
      OP_OR:   raw = o | s;
      OP_AND:  raw = o & s;
      OP_XOR:  raw = o ^ s;
      OP_XCHG: raw = s;
      OP_CMPX: raw = cmp_ok ? s : o;
      default: raw = o;
    endcase
  end

  assign new_val = raw & mask;
  assign old_val = o;

  always_comb begin
    if (!dword) begin
      assert_word_upper_zero_R3: assert (new_val[DATA_W-1:HALF_W] == '0 && old_val[DATA_W-1:HALF_W] == '0);
    end
  end
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 64,
  parameter int OFF_W  = 16,
  parameter int IMM_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_src,
  input  logic [DATA_W-1:0] req_r0,
  input  logic [1:0]        req_size,
  input  logic [IMM_W-1:0]  req_imm,
  output logic              mem_en,
  output logic              mem_we,
  output logic              mem_dword,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_lock,
  output logic              done,
  output logic              err,
  output logic              src_we,
  output logic [DATA_W-1:0] src_val,
  output logic              r0_we,
  output logic [DATA_W-1:0] r0_val
);
  localparam int EXT_W = ADDR_W - OFF_W;

  atom_state_e       state;
  atom_op_e          dec_op, op_q;
  logic              dec_fetch, dec_dword, dec_bad;
  logic              fetch_q, dword_q, err_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] src_q, r0_q, old_q, new_q;
  logic [DATA_W-1:0] alu_old, alu_new;
  logic              alu_cmp;
  logic              accept;

  atom_decode #(.IMM_W(IMM_W)) u_dec (
    .imm(req_imm), .size(req_size),
    .op(dec_op), .fetch(dec_fetch), .dword(dec_dword), .bad(dec_bad)
  );

  atom_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .dword(dword_q), .mem_old(mem_rdata), .src(src_q), .r0(r0_q),
    .old_val(alu_old), .new_val(alu_new), .cmp_ok(alu_cmp)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_ADD;
      fetch_q <= 1'b0;
      dword_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      src_q   <= '0;
      r0_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q    <= dec_op;
          fetch_q <= dec_fetch;
          dword_q <= dec_dword;
          err_q   <= dec_bad;
          addr_q  <= req_base + {{EXT_W{req_offset[OFF_W-1]}}, req_offset};
          src_q   <= req_src;
          r0_q    <= req_r0;
          state   <= dec_bad ? ST_DONE : ST_READ;
        end
        ST_READ: state <= ST_CALC;
        ST_CALC: begin
          old_q <= alu_old;
          new_q <= alu_new;
          state <= (op_q == OP_CMPX && !alu_cmp) ? ST_DONE : ST_WRITE;
        end
        ST_WRITE: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign mem_en    = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we    = (state == ST_WRITE);
  assign mem_dword = dword_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = new_q;
  assign mem_lock  = (state == ST_READ) || (state == ST_CALC) || (state == ST_WRITE);

  assign done    = (state == ST_DONE);
  assign err     = done && err_q;
  assign src_we  = done && !err_q && fetch_q && (op_q != OP_CMPX);
  assign r0_we   = done && !err_q && (op_q == OP_CMPX);
  assign src_val = old_q;
  assign r0_val  = old_q;

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_lock_covers_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_lock);
  assert_write_after_locked_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |-> $past(mem_lock));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_no_writeback_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(src_we || r0_we) && !mem_en);
  assert_addr_stable_in_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock && $past(mem_lock)) |-> $stable(mem_addr));
endmodule

// File: tb/tb_atomic_rmw_unit.sv
module tb_atomic_rmw_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [63:0] req_base, req_src, req_r0;
  logic [15:0] req_offset;
  logic [1:0]  req_size;
  logic [31:0] req_imm;
  logic        mem_en, mem_we, mem_dword, mem_lock;
  logic [63:0] mem_addr, mem_wdata, mem_rdata;
  logic        done, err, src_we, r0_we;
  logic [63:0] src_val, r0_val;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  atomic_rmw_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offset(req_offset), .req_src(req_src), .req_r0(req_r0),
    .req_size(req_size), .req_imm(req_imm), .mem_en(mem_en), .mem_we(mem_we),
    .mem_dword(mem_dword), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_lock(mem_lock), .done(done), .err(err),
    .src_we(src_we), .src_val(src_val), .r0_we(r0_we), .r0_val(r0_val)
  );

  // memory model: 16 doublewords, word halves picked by address bit 2
  logic [63:0] mem [0:15];
  int          rd_cnt, wr_cnt, nolock_cnt, upper_bad;
  logic [63:0] rd_addr, wr_addr, wr_data;
  logic        wr_dw;

  always @(posedge clk) begin
    if (mem_en && !mem_lock) nolock_cnt <= nolock_cnt + 1;
    if (mem_en && !mem_we) begin
      rd_cnt  <= rd_cnt + 1;
      rd_addr <= mem_addr;
      if (mem_dword) mem_rdata <= mem[mem_addr[6:3]];
      else if (mem_addr[2]) mem_rdata <= {~mem[mem_addr[6:3]][63:32], mem[mem_addr[6:3]][63:32]};
      else mem_rdata <= {~mem[mem_addr[6:3]][31:0], mem[mem_addr[6:3]][31:0]};
    end
    if (mem_en && mem_we) begin
      wr_cnt  <= wr_cnt + 1;
      wr_addr <= mem_addr;
      wr_data <= mem_wdata;
      wr_dw   <= mem_dword;
      if (mem_dword) mem[mem_addr[6:3]] <= mem_wdata;
      else begin
        if (mem_wdata[63:32] != 32'h0) upper_bad <= upper_bad + 1;
        if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
        else             mem[mem_addr[6:3]][31:0]  <= mem_wdata[31:0];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal_imm(input logic [31:0] imm);
    case (imm)
      32'h00, 32'h01, 32'h40, 32'h41, 32'h50, 32'h51, 32'hA0, 32'hA1, 32'hE1, 32'hF1: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] read_old(input logic [63:0] ea, input logic [1:0] sz);
    if (sz == 2'b11) return mem[ea[6:3]];
    return ea[2] ? {32'h0, mem[ea[6:3]][63:32]} : {32'h0, mem[ea[6:3]][31:0]};
  endfunction

  task automatic run_op(input logic [1:0] sz, input logic [31:0] imm, input logic [63:0] ea,
                        input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0);
    logic [63:0] m, o, s, r, nv;
    bit          legal, dw, wr, exp_swe, exp_rwe;
    int          lat, exp_lat, rd0, wr0;
    legal = legal_imm(imm) && (sz == 2'b00 || sz == 2'b11);
    dw = (sz == 2'b11);
    m  = dw ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    o  = read_old(ea, sz) & m;
    s  = src & m;
    r  = r0 & m;
    wr = 1'b1;
    case (imm[7:4])
      4'h0: nv = (o + s) & m;
      4'h4: nv = o | s;
      4'h5: nv = o & s;
      4'hA: nv = o ^ s;
      4'hE: nv = s;
      default: begin nv = s; wr = (o == r); end
    endcase
    exp_swe = legal && imm[0] && imm != 32'hF1;
    exp_rwe = legal && imm == 32'hF1;
    if (!legal) begin wr = 1'b0; exp_lat = 1; end
    else exp_lat = wr ? 4 : 3;

    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    check(req_ready == 1'b1, "R1 ready while idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_size = sz; req_imm = imm; req_offset = off;
    req_base = ea - {{48{off[15]}}, off}; req_src = src; req_r0 = r0;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!done && lat < 10) begin
      check(req_ready == 1'b0, "R1 ready low while busy", 64'(req_ready), 64'd0);
      check(src_we == 1'b0 && r0_we == 1'b0, "R10 write-back only with done",
            64'({src_we, r0_we}), 64'd0);
      @(negedge clk);
      lat++;
    end
    check(lat == exp_lat, legal ? "R11 done latency" : "R8 error latency", 64'(lat), 64'(exp_lat));
    check(err == !legal, "R8 err flag", 64'(err), 64'(!legal));
    check(src_we == exp_swe, "R5 src_we", 64'(src_we), 64'(exp_swe));
    check(r0_we == exp_rwe, "R7 r0_we", 64'(r0_we), 64'(exp_rwe));
    if (exp_swe) check(src_val == o, imm == 32'hE1 ? "R6 exchange old value" : "R5 fetch old value", src_val, o);
    if (exp_rwe) check(r0_val == o, "R7 compare-exchange old value to R0", r0_val, o);
    check(rd_cnt - rd0 == (legal ? 1 : 0), "R8 read count", 64'(rd_cnt - rd0), 64'(legal));
    check(wr_cnt - wr0 == (wr ? 1 : 0), imm == 32'hF1 ? "R7 conditional write" : "R4 write count",
          64'(wr_cnt - wr0), 64'(wr));
    if (legal) check(rd_addr == ea, "R2 read address", rd_addr, ea);
    if (wr) begin
      check(wr_addr == ea, "R2 write address", wr_addr, ea);
      check(wr_data == nv, imm[7:4] == 4'hE ? "R6 exchange data" : "R4 written value", wr_data, nv);
      check(wr_dw == dw, "R3 access width", 64'(wr_dw), 64'(dw));
    end
    @(negedge clk);
    check(done == 1'b0, "R10 done single cycle", 64'(done), 64'd0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    automatic logic [31:0] imm_set [10] = '{32'h00, 32'h01, 32'h40, 32'h41, 32'h50,
                                            32'h51, 32'hA0, 32'hA1, 32'hE1, 32'hF1};
    void'($urandom(32'd4242));
    rd_cnt = 0; wr_cnt = 0; nolock_cnt = 0; upper_bad = 0;
    mem_rdata = '0;
    req_valid = 1'b0; req_base = '0; req_offset = '0; req_src = '0; req_r0 = '0;
    req_size = 2'b00; req_imm = '0;
    for (int i = 0; i < 16; i++) mem[i] = rnd64();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && !done && !mem_en && !mem_lock, "R12 reset state",
          64'({req_ready, done, mem_en, mem_lock}), 64'b1000);
    rst_n = 1'b1;

    // directed corners
    mem[2] = 64'h0000_0001_FFFF_FFFF;
    run_op(2'b00, 32'h01, 64'h10, 16'hFFF0, 64'h1, 64'h0);                // R3 word add wrap
    check(mem[2] == 64'h0000_0001_0000_0000, "R3 word add wraps in low half", mem[2], 64'h0000_0001_0000_0000);
    mem[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    run_op(2'b11, 32'h00, 64'h18, 16'h0008, 64'h1, 64'h0);                // R4 dword wrap, no fetch
    check(mem[3] == 64'h0, "R4 dword add wraps", mem[3], 64'h0);
    mem[4] = 64'h1234_5678_9ABC_DEF0;
    run_op(2'b11, 32'hF1, 64'h20, 16'h8000, 64'hAAAA, 64'h1234_5678_9ABC_DEF0); // R7 match
    check(mem[4] == 64'hAAAA, "R7 match stores source", mem[4], 64'hAAAA);
    run_op(2'b11, 32'hF1, 64'h20, 16'h7FFF, 64'hBBBB, 64'h5);             // R7 mismatch
    check(mem[4] == 64'hAAAA, "R7 mismatch keeps memory", mem[4], 64'hAAAA);
    mem[5] = 64'hDEAD_BEEF_0000_0007;
    run_op(2'b00, 32'hF1, 64'h2C, 16'h0004, 64'h99, 64'hFFFF_FFFF_DEAD_BEEF); // R7 word compare low bits
    check(mem[5] == 64'h0000_0099_0000_0007, "R7 word compare uses low 32 bits", mem[5], 64'h0000_0099_0000_0007);
    mem[6] = 64'h55;
    run_op(2'b11, 32'hE1, 64'h30, 16'h0, 64'hCAFE, 64'h0);                // R6 exchange
    check(mem[6] == 64'hCAFE, "R6 exchange stores source", mem[6], 64'hCAFE);
    run_op(2'b11, 32'h02, 64'h30, 16'h0, 64'h1, 64'h0);                   // R8 bad imm
    run_op(2'b01, 32'h00, 64'h30, 16'h0, 64'h1, 64'h0);                   // R8 bad size
    run_op(2'b11, 32'h0000_0100, 64'h30, 16'h0, 64'h1, 64'h0);            // R8 upper imm bits
    check(mem[6] == 64'hCAFE, "R8 rejected requests leave memory", mem[6], 64'hCAFE);

    // constrained random
    for (int k = 0; k < 300; k++) begin
      automatic logic [1:0]  sz  = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'b11;
      automatic logic [31:0] imm = imm_set[$urandom_range(0, 9)];
      automatic logic [63:0] ea  = {57'h0, 4'($urandom_range(0, 15)), 3'b000};
      automatic logic [63:0] r0v = rnd64();
      if ($urandom_range(0, 19) == 0) imm = $urandom() & 32'hFF;
      if ($urandom_range(0, 29) == 0) sz = 2'($urandom_range(1, 2));
      if (sz == 2'b00) ea[2] = 1'($urandom_range(0, 1));
      if (imm == 32'hF1 && $urandom_range(0, 1) == 1) r0v = read_old(ea, sz);
      run_op(sz, imm, ea + 64'h4000_0000_0000_0000, 16'($urandom()), rnd64(), r0v);
    end

    check(nolock_cnt == 0, "R9 access only under lock", 64'(nolock_cnt), 64'd0);
    check(upper_bad == 0, "R3 word write upper bits zero", 64'(upper_bad), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule